// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block keeps the pending, in-service and trigger-mode state for 256 interrupt vectors. Each state is a bit array split into eight 32-bit words. It decides whether the processor should be interrupted. The decision weighs the strongest pending vector against a processor priority, which is formed from a software-written task priority and the strongest vector already in service. Priority is compared per class of 16 vectors, using the upper nibble of the vector number.

Requests arrive on a strobe that carries a vector number and a level/edge flag. The processor takes an interrupt with a one-cycle acknowledge strobe. The winning vector, or the spurious vector when the acknowledge is refused, is returned one clock later. The handler finishes by writing the end-of-interrupt register. A word-wide register port gives access to the task priority, the processor priority, the spurious/enable register and every word of the three bit arrays. The register index is taken from address bits [11:4].

Top module: `prio_intc`

## Requirements
- R1: The strongest entry of a bit array is its highest-numbered set bit over all eight words. Vector v sits in word v/32, bit v%32.
- R2: Processor priority (index 0x0A, read-only) equals TPR when TPR[7:4] >= the class (bits [7:4]) of the strongest in-service vector. Otherwise it equals that class followed by four zero bits. An empty in-service array counts as class 0.
- R3: `irq_out` is high only when all of the following hold: spurious-register bit 8 is set, at least one pending bit is set, and either processor priority is 0 or the strongest pending class is strictly above the processor-priority class. It changes on the same clock edge that updates the state it depends on.
- R4: A request sets the pending bit of its vector. It sets the trigger-mode bit when `req_level` is 1 and clears it when `req_level` is 0.
- R5: An acknowledge is refused when TPR is nonzero and the strongest pending vector is <= TPR, compared as full bytes. Otherwise the strongest pending bit moves to the in-service array. `ack_valid` pulses one cycle after `ack_req`, and `ack_vector` carries either the moved vector or the spurious register's low byte.
- R6: A write to index 0x0B clears the highest set in-service bit and does nothing when the in-service array is empty.
- R7: An acknowledge while bit 8 of the spurious register is clear, or while no pending bit is set, returns the spurious register's low byte and leaves all arrays unchanged.
- R8: After reset, TPR, pending, in-service and trigger-mode arrays are zero, the spurious register reads 0x0FF, `irq_out` is 0 and `ack_valid` is 0.
- R9: A request and an acknowledge in the same cycle both take effect. The acknowledge is resolved against the state before the request.
- R10: Register map, by index: 0x08 TPR (8 bits written), 0x0F spurious register (bits [8:0] written), 0x10+n in-service word n, 0x18+n trigger-mode word n, 0x20+n pending word n. Writes to the read-only indices are ignored, and reads of an unmapped index return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_vector | input | 8 | Vector number of the request |
| req_level | input | 1 | 1 = level-triggered request, 0 = edge |
| ack_req | input | 1 | Acknowledge strobe from the processor |
| ack_valid | output | 1 | Acknowledge response valid, one cycle after ack_req |
| ack_vector | output | 8 | Returned vector or spurious vector |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address, index in bits [11:4] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
A request, acknowledge, end-of-interrupt or register write takes effect on the next rising edge. Register reads are combinational, so a readback is sampled at the falling edge that follows the stimulus edge. The interrupt output is computed from next-state values, so it is also valid at that first falling edge, with no second cycle of lag. The acknowledge response is registered and is checked at the same falling edge, one cycle after the strobe. The bench drives every stimulus on a falling edge, waits exactly one rising edge, and then compares, so each check sits on the cycle where its result first becomes due.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  typedef logic [7:0] vec_t;

  // register indices (address bits [11:4])
  localparam logic [7:0] IDX_TPR  = 8'h08;
  localparam logic [7:0] IDX_PPR  = 8'h0A;
  localparam logic [7:0] IDX_EOI  = 8'h0B;
  localparam logic [7:0] IDX_SPUR = 8'h0F;
  localparam logic [7:0] IDX_ISR0 = 8'h10;
  localparam logic [7:0] IDX_TMR0 = 8'h18;
  localparam logic [7:0] IDX_IRR0 = 8'h20;

  localparam logic [8:0] SPUR_RST = 9'h0FF;
  localparam int         EN_BIT   = 8;

  // processor priority from task priority and strongest in-service vector
  function automatic vec_t calc_ppr(input vec_t tpr, input logic isr_any,
                                    input vec_t isr_top);
    logic [3:0] cls;
    cls = isr_any ? isr_top[7:4] : 4'h0;
    if (tpr[7:4] >= cls) return tpr;
    return {cls, 4'h0};
  endfunction

  // interrupt decision by 16-vector class
  function automatic logic irq_decide(input logic en, input logic irr_any,
                                      input vec_t irr_top, input vec_t ppr);
    return en && irr_any && ((ppr == 8'h00) || (irr_top[7:4] > ppr[7:4]));
  endfunction

  // acknowledge refused: disabled, nothing pending, or masked by TPR
  function automatic logic ack_refused(input logic en, input logic irr_any,
                                       input vec_t irr_top, input vec_t tpr);
    return !en || !irr_any || ((tpr != 8'h00) && (irr_top <= tpr));
  endfunction

endpackage

// File: rtl/pic_msb_enc.sv
module pic_msb_enc #(
  parameter  int WORD_W    = 32,
  parameter  int NUM_WORDS = 8,
  localparam int TOTAL     = WORD_W * NUM_WORDS,
  localparam int BW        = $clog2(WORD_W),
  localparam int WW        = $clog2(NUM_WORDS)
) (
  input  logic [TOTAL-1:0]  bits_i,
  output logic              found_o,
  output logic [WW+BW-1:0]  idx_o
);

  logic [NUM_WORDS-1:0]         word_hit;
  logic [NUM_WORDS-1:0][BW-1:0] word_pos;

  // first level: per-word presence
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign word_hit[w] = |bits_i[w*WORD_W +: WORD_W];
  end

  // first level: highest bit inside each word
  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      word_pos[w] = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (bits_i[w*WORD_W + b]) word_pos[w] = BW'(b);
      end
    end
  end

  // second level: highest word with any bit set
  always_comb begin
    idx_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_hit[w]) idx_o = {WW'(w), word_pos[w]};
    end
  end

  assign found_o = |word_hit;

endmodule

// File: rtl/pic_reg_rd.sv
module pic_reg_rd
  import prio_intc_pkg::*;
#(
  parameter  int WORD_W    = 32,
  parameter  int NUM_WORDS = 8,
  localparam int TOTAL     = WORD_W * NUM_WORDS
) (
  input  logic [7:0]        idx_i,
  input  vec_t              tpr_i,
  input  vec_t              ppr_i,
  input  logic [8:0]        spur_i,
  input  logic [TOTAL-1:0]  isr_i,
  input  logic [TOTAL-1:0]  tmr_i,
  input  logic [TOTAL-1:0]  irr_i,
  output logic [WORD_W-1:0] rdata_o
);

  localparam logic [7:0] ISR_END = IDX_ISR0 + 8'(NUM_WORDS);
  localparam logic [7:0] TMR_END = IDX_TMR0 + 8'(NUM_WORDS);
  localparam logic [7:0] IRR_END = IDX_IRR0 + 8'(NUM_WORDS);

  logic in_isr, in_tmr, in_irr;
  int   off;

  assign in_isr = (idx_i >= IDX_ISR0) && (idx_i < ISR_END);
  assign in_tmr = (idx_i >= IDX_TMR0) && (idx_i < TMR_END);
  assign in_irr = (idx_i >= IDX_IRR0) && (idx_i < IRR_END);

  always_comb begin
    rdata_o = '0;
    off     = 0;
    if (idx_i == IDX_TPR) begin
      rdata_o = WORD_W'(tpr_i);
    end else if (idx_i == IDX_PPR) begin
      rdata_o = WORD_W'(ppr_i);
    end else if (idx_i == IDX_SPUR) begin
      rdata_o = WORD_W'(spur_i);
    end else if (in_isr) begin
      off     = int'(idx_i - IDX_ISR0);
      rdata_o = isr_i[off*WORD_W +: WORD_W];
    end else if (in_tmr) begin
      off     = int'(idx_i - IDX_TMR0);
      rdata_o = tmr_i[off*WORD_W +: WORD_W];
    end else if (in_irr) begin
      off     = int'(idx_i - IDX_IRR0);
      rdata_o = irr_i[off*WORD_W +: WORD_W];
    end
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter  int WORD_W    = 32,
  parameter  int NUM_WORDS = 8,
  parameter  int ADDR_W    = 12,
  localparam int NUM_VEC   = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [7:0]        req_vector,
  input  logic              req_level,
  input  logic              ack_req,
  output logic              ack_valid,
  output logic [7:0]        ack_vector,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_out
);

  // state
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
  vec_t               tpr_q, tpr_d;
  logic [8:0]         spur_q, spur_d;
  logic               irq_d;

  // register decode
  logic [7:0] reg_idx;
  logic       wr_tpr, wr_spur, wr_eoi;
  logic       unused_bits;

  assign reg_idx     = reg_addr[ADDR_W-1:4];
  assign wr_tpr      = reg_we && (reg_idx == IDX_TPR);
  assign wr_spur     = reg_we && (reg_idx == IDX_SPUR);
  assign wr_eoi      = reg_we && (reg_idx == IDX_EOI);
  assign unused_bits = ^{reg_addr[3:0], reg_wdata[WORD_W-1:9]};

  // priority search on current state
  logic irr_any, isr_any;
  vec_t irr_top, isr_top;

  pic_msb_enc #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_irr_cur (
    .bits_i(irr_q), .found_o(irr_any), .idx_o(irr_top));
  pic_msb_enc #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_isr_cur (
    .bits_i(isr_q), .found_o(isr_any), .idx_o(isr_top));

  // named internal events
  vec_t ppr_w;
  logic ack_spur, ack_take, eoi_take;

  assign ppr_w    = calc_ppr(tpr_q, isr_any, isr_top);
  assign ack_spur = ack_refused(spur_q[EN_BIT], irr_any, irr_top, tpr_q);
  assign ack_take = ack_req && !ack_spur;
  assign eoi_take = wr_eoi && isr_any;

  // next state: acknowledge resolved on old state, request applied after
  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (ack_take) irr_d[irr_top] = 1'b0;
    if (req_valid) begin
      irr_d[req_vector] = 1'b1;
      tmr_d[req_vector] = req_level;
    end
    if (eoi_take) isr_d[isr_top] = 1'b0;
    if (ack_take) isr_d[irr_top] = 1'b1;
    tpr_d  = wr_tpr  ? reg_wdata[7:0] : tpr_q;
    spur_d = wr_spur ? reg_wdata[8:0] : spur_q;
  end

  // priority search on next state for the registered interrupt output
  logic irr_nx_any, isr_nx_any;
  vec_t irr_nx_top, isr_nx_top;

  pic_msb_enc #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_irr_nxt (
    .bits_i(irr_d), .found_o(irr_nx_any), .idx_o(irr_nx_top));
  pic_msb_enc #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_isr_nxt (
    .bits_i(isr_d), .found_o(isr_nx_any), .idx_o(isr_nx_top));

  assign irq_d = irq_decide(spur_d[EN_BIT], irr_nx_any, irr_nx_top,
                            calc_ppr(tpr_d, isr_nx_any, isr_nx_top));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q      <= '0;
      isr_q      <= '0;
      tmr_q      <= '0;
      tpr_q      <= '0;
      spur_q     <= SPUR_RST;
      irq_out    <= 1'b0;
      ack_valid  <= 1'b0;
      ack_vector <= '0;
    end else begin
      irr_q     <= irr_d;
      isr_q     <= isr_d;
      tmr_q     <= tmr_d;
      tpr_q     <= tpr_d;
      spur_q    <= spur_d;
      irq_out   <= irq_d;
      ack_valid <= ack_req;
      if (ack_req) ack_vector <= ack_spur ? spur_q[7:0] : irr_top;
    end
  end

  pic_reg_rd #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_rd (
    .idx_i  (reg_idx),
    .tpr_i  (tpr_q),
    .ppr_i  (ppr_w),
    .spur_i (spur_q),
    .isr_i  (isr_q),
    .tmr_i  (tmr_q),
    .irr_i  (irr_q),
    .rdata_o(reg_rdata)
  );

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int NUM_VEC = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [7:0]         req_vector,
  input logic               req_level,
  input logic               ack_req,
  input logic               ack_valid,
  input logic [7:0]         ack_vector,
  input logic               irq_out,
  input logic [NUM_VEC-1:0] irr_q,
  input logic [NUM_VEC-1:0] isr_q,
  input logic [NUM_VEC-1:0] tmr_q,
  input logic [7:0]         tpr_q,
  input logic [8:0]         spur_q,
  input logic [7:0]         ppr_w,
  input logic               isr_any,
  input logic [7:0]         isr_top,
  input logic [7:0]         irr_top,
  input logic               ack_take,
  input logic               eoi_take
);

  p_ppr_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_w >= tpr_q);

  p_ppr_isr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    isr_any |-> ppr_w[7:4] >= isr_top[7:4]);

  p_irq_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !spur_q[8] |-> !irq_out);

  p_irq_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_q == '0) |-> !irq_out);

  p_irq_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && ppr_w != 8'h00) |-> (irr_top[7:4] > ppr_w[7:4]));

  p_req_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (irr_q[$past(req_vector)] &&
                   (tmr_q[$past(req_vector)] == $past(req_level))));

  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_valid);

  p_ack_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (isr_q[ack_vector] && ack_vector == $past(irr_top)));

  p_ack_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_take) |=> ack_vector == $past(spur_q[7:0]));

  p_eoi_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_take && !ack_take) |=> !isr_q[$past(isr_top)]);

endmodule

bind prio_intc prio_intc_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_vector(req_vector),
  .req_level (req_level),
  .ack_req   (ack_req),
  .ack_valid (ack_valid),
  .ack_vector(ack_vector),
  .irq_out   (irq_out),
  .irr_q     (irr_q),
  .isr_q     (isr_q),
  .tmr_q     (tmr_q),
  .tpr_q     (tpr_q),
  .spur_q    (spur_q),
  .ppr_w     (ppr_w),
  .isr_any   (isr_any),
  .isr_top   (isr_top),
  .irr_top   (irr_top),
  .ack_take  (ack_take),
  .eoi_take  (eoi_take)
);

// File: tb/tb_prio_intc.sv
`timescale 1ns/1ps
module tb_prio_intc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vector = '0;
  logic        req_level = 1'b0;
  logic        ack_req = 1'b0;
  logic        ack_valid;
  logic [7:0]  ack_vector;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  prio_intc dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
    .ack_req(ack_req), .ack_valid(ack_valid), .ack_vector(ack_vector),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // register indices as the requirements give them
  localparam logic [7:0] I_TPR = 8'h08, I_PPR = 8'h0A, I_EOI = 8'h0B,
                         I_SPUR = 8'h0F, I_ISR = 8'h10, I_TMR = 8'h18,
                         I_IRR = 8'h20;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_req(input logic [7:0] v, input logic lvl);
    req_valid = 1'b1; req_vector = v; req_level = lvl;
    step();
    req_valid = 1'b0;
  endtask

  task automatic do_ack(output logic [7:0] v);
    ack_req = 1'b1;
    step();
    ack_req = 1'b0;
    chk("R5 ack_valid pulse", 32'(ack_valid), 32'd1);
    v = ack_vector;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = {idx, 4'h0}; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [31:0] d);
    reg_addr = {idx, 4'h0};
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] idx, input logic [31:0] exp);
    logic [31:0] d;
    rd(idx, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset();
    chk("R8 irq after reset", 32'(irq_out), 0);
    chk("R8 ack_valid after reset", 32'(ack_valid), 0);
    chk_reg("R8 spurious reset", I_SPUR, 32'h0FF);
    chk_reg("R8 tpr reset", I_TPR, 0);
    chk_reg("R8 ppr reset", I_PPR, 0);
    for (int w = 0; w < 8; w++) begin
      chk_reg("R8 irr word reset", I_IRR + 8'(w), 0);
      chk_reg("R8 isr word reset", I_ISR + 8'(w), 0);
      chk_reg("R8 tmr word reset", I_TMR + 8'(w), 0);
    end
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    do_req(8'h45, 1'b0);
    chk("R3 no irq while disabled", 32'(irq_out), 0);
    chk_reg("R4 irr bit 0x45", I_IRR + 8'd2, 32'h20);
    chk_reg("R4 tmr clear for edge", I_TMR + 8'd2, 0);
    do_ack(v);
    chk("R7 disabled ack gives spurious", 32'(v), 32'hFF);
    chk_reg("R7 irr kept on disabled ack", I_IRR + 8'd2, 32'h20);
    chk_reg("R7 isr untouched on disabled ack", I_ISR + 8'd2, 0);
  endtask

  task automatic t_enable();
    wr(I_SPUR, 32'hFFFF_F1FF);
    chk_reg("R10 spurious keeps 9 bits", I_SPUR, 32'h1FF);
    chk("R3 irq once enabled", 32'(irq_out), 1);
  endtask

  task automatic t_trigger();
    do_req(8'h47, 1'b1);
    chk_reg("R4 tmr set for level", I_TMR + 8'd2, 32'h80);
    chk_reg("R4 irr two bits", I_IRR + 8'd2, 32'hA0);
    do_req(8'h47, 1'b0);
    chk_reg("R4 tmr cleared by edge", I_TMR + 8'd2, 0);
  endtask

  task automatic t_ack_class();
    logic [7:0] v;
    do_ack(v);
    chk("R1 top vector 0x47", 32'(v), 32'h47);
    chk_reg("R5 irr bit removed", I_IRR + 8'd2, 32'h20);
    chk_reg("R5 isr bit set", I_ISR + 8'd2, 32'h80);
    chk_reg("R2 ppr from isr class", I_PPR, 32'h40);
    chk("R3 equal class blocks irq", 32'(irq_out), 0);
  endtask

  task automatic t_nest_eoi();
    logic [7:0] v;
    do_req(8'h50, 1'b0);
    chk("R3 higher class raises irq", 32'(irq_out), 1);
    do_ack(v);
    chk("R5 nested vector 0x50", 32'(v), 32'h50);
    chk_reg("R2 ppr nested", I_PPR, 32'h50);
    chk_reg("R5 isr two bits", I_ISR + 8'd2, 32'h0001_0080);
    wr(I_EOI, 0);
    chk_reg("R6 eoi clears highest", I_ISR + 8'd2, 32'h80);
    chk_reg("R6 ppr after eoi", I_PPR, 32'h40);
    chk("R3 irq still blocked", 32'(irq_out), 0);
    wr(I_EOI, 0);
    chk_reg("R6 isr empty", I_ISR + 8'd2, 0);
    chk_reg("R2 ppr zero when empty", I_PPR, 0);
    chk("R3 irq with ppr zero", 32'(irq_out), 1);
    do_ack(v);
    chk("R5 vector 0x45", 32'(v), 32'h45);
    wr(I_EOI, 0);
    chk("R3 irq low with nothing pending", 32'(irq_out), 0);
    wr(I_EOI, 0);
    chk_reg("R6 eoi on empty is harmless", I_ISR + 8'd2, 0);
  endtask

  task automatic t_tpr();
    logic [7:0] v;
    wr(I_TPR, 32'h60);
    chk_reg("R10 tpr readback", I_TPR, 32'h60);
    chk_reg("R2 ppr follows tpr", I_PPR, 32'h60);
    do_req(8'h65, 1'b0);
    chk("R3 class equal to tpr blocks irq", 32'(irq_out), 0);
    do_ack(v);
    chk("R5 full-byte compare accepts 0x65", 32'(v), 32'h65);
    chk_reg("R2 tpr class wins tie", I_PPR, 32'h60);
    wr(I_EOI, 0);
    wr(I_SPUR, 32'h1A7);
    do_req(8'h55, 1'b0);
    chk("R3 below tpr no irq", 32'(irq_out), 0);
    do_ack(v);
    chk("R5 masked ack gives spurious", 32'(v), 32'hA7);
    chk_reg("R5 irr kept on masked ack", I_IRR + 8'd2, 32'h0020_0000);
    chk_reg("R5 isr unchanged on masked ack", I_ISR + 8'd2, 0);
    wr(I_TPR, 0);
    chk("R3 irq after tpr cleared", 32'(irq_out), 1);
    do_ack(v);
    chk("R5 vector 0x55", 32'(v), 32'h55);
    wr(I_EOI, 0);
  endtask

  task automatic t_empty_ack();
    logic [7:0] v;
    do_ack(v);
    chk("R7 empty ack gives spurious", 32'(v), 32'hA7);
    chk_reg("R7 isr untouched", I_ISR + 8'd2, 0);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    do_req(8'h30, 1'b0);
    req_valid = 1'b1; req_vector = 8'h90; req_level = 1'b0;
    ack_req = 1'b1;
    step();
    req_valid = 1'b0; ack_req = 1'b0;
    v = ack_vector;
    chk("R9 ack uses old state", 32'(v), 32'h30);
    chk_reg("R9 new request pending", I_IRR + 8'd4, 32'h0001_0000);
    chk_reg("R9 old vector left irr", I_IRR + 8'd1, 0);
    chk_reg("R9 old vector in service", I_ISR + 8'd1, 32'h0001_0000);
    chk("R3 irq for higher class", 32'(irq_out), 1);
    do_ack(v);
    chk("R9 later ack 0x90", 32'(v), 32'h90);
    wr(I_EOI, 0);
    wr(I_EOI, 0);
  endtask

  task automatic t_words();
    logic [7:0] v;
    do_req(8'h03, 1'b0);
    do_req(8'hE1, 1'b0);
    do_ack(v);
    chk("R1 search across words", 32'(v), 32'hE1);
    chk_reg("R1 isr word 7", I_ISR + 8'd7, 32'h2);
    do_ack(v);
    chk("R1 low word vector", 32'(v), 32'h03);
    wr(I_EOI, 0);
    chk_reg("R6 highest cleared first", I_ISR + 8'd7, 0);
    chk_reg("R6 lower isr kept", I_ISR + 8'd0, 32'h8);
    wr(I_EOI, 0);
    chk_reg("R6 lower isr cleared", I_ISR + 8'd0, 0);
  endtask

  task automatic t_readonly();
    logic [7:0] v;
    do_req(8'h21, 1'b0);
    wr(I_IRR + 8'd1, 32'hFFFF_FFFF);
    chk_reg("R10 irr write ignored", I_IRR + 8'd1, 32'h2);
    wr(I_PPR, 32'h77);
    chk_reg("R10 ppr write ignored", I_PPR, 0);
    chk_reg("R10 unmapped reads zero", 8'h05, 0);
    wr(I_TPR, 32'h1234);
    chk_reg("R10 tpr keeps 8 bits", I_TPR, 32'h34);
    wr(I_TPR, 0);
    do_ack(v);
    chk("R5 vector 0x21", 32'(v), 32'h21);
    wr(I_EOI, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_enable();
    t_trigger();
    t_ack_class();
    t_nest_eoi();
    t_tpr();
    t_empty_ack();
    t_same_cycle();
    t_words();
    t_readonly();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule